// File: doc/BRIEF.md
# Fan PWM Generator

This block drives a fan with a pulse-width-modulated signal. Software programs it through a small byte-wide register bus: a 6-bit drive code, a 5-bit period value, an 8-bit alternate divisor and a 3-bit configuration field. The configuration field holds output inversion, divisor override and default-divisor select.

A base clock is first divided by a prescaler. The prescaler uses one of two fixed default ratios, or the programmable divisor when override is set. The prescaled ticks advance a period counter, and that counter sets both the PWM frequency and the number of duty steps. The drive code always means the same thing: zero is the least drive and 3Fh is the most drive. Inversion only flips the physical level on the pin.

Period, divisor and drive updates are held in shadow registers. They are loaded only at the end of a PWM period, so the output never shows a truncated or stretched pulse.

Top module: `fan_pwm_gen`

## Requirements
- R1: After reset the registers read drive 00h, period 17h, divisor 01h and configuration 00h, and `fan_out` is low.
- R2: Register map. Configuration is at 4Ah: bit0 inverts the output, bit1 selects the programmable divisor, bit2 selects the default ratio, and bits 7:3 read 0. Drive is at 4Ch in bits 5:0, and bits 7:6 read 0. Period value F is at 4Dh in bits 4:0, and bits 7:5 read 0. Divisor is at 4Eh and uses all 8 bits. Any other address reads 00h. Reads are combinational and return the stored contents.
- R3: With F > 0 the output period is (2F+1)*D base-clock cycles, where D is the effective prescaler ratio.
- R4: Active time per period is floor(drive*(2F+1)/63)*D cycles. Drive 00h gives no active time, and drive 3Fh keeps the output active all the time.
- R5: The inversion bit flips the pin level only. The active time measured on the active level is the same for either setting.
- R6: With F = 0 the output stays at the inactive level: low when not inverted, high when inverted.
- R7: With the override bit at 0, D is 4 when bit2 is 0 and 8 when bit2 is 1. The divisor register is then ignored but keeps its written value.
- R8: With the override bit at 1, D equals the divisor register value, and a value of 00h acts as 01h.
- R9: New drive, period and divisor values take effect only at the next period boundary. A pulse already in progress completes with the old values.
- R10: A change of the inversion bit reaches `fan_out` within two clock cycles of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| fan_out | output | 1 | PWM fan drive |

## Verification
Read data is due in the same cycle that the address is applied, and a written value is visible from the next cycle. An inversion change is due on the pin two edges after the write. Duty and period changes are due only after the current period has ended, which can be up to one full old period later. For this reason the bench lets several old periods pass before it measures. It then counts active and inactive cycles between edges of the output, so no check depends on a fixed latency. The boundary test instead starts a write on the first active sample of a pulse and expects that same pulse to keep its old width.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;
  localparam int REG_W = 8;
  localparam int DRV_W = 6;
  localparam int FRQ_W = 5;
  localparam int DIV_W = 8;
  localparam int CFG_W = 3;

  localparam logic [REG_W-1:0] ADDR_CFG   = 8'h4A;
  localparam logic [REG_W-1:0] ADDR_DRIVE = 8'h4C;
  localparam logic [REG_W-1:0] ADDR_FREQ  = 8'h4D;
  localparam logic [REG_W-1:0] ADDR_DIV   = 8'h4E;

  localparam logic [FRQ_W-1:0] FRQ_RST = 5'h17;
  localparam logic [DIV_W-1:0] DIV_RST = 8'h01;

  typedef struct packed {
    logic clk_sel;
    logic override;
    logic invert;
  } cfg_t;
endpackage

// File: rtl/fan_pwm_regs.sv
module fan_pwm_regs
  import fan_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             we,
  output logic [REG_W-1:0] rdata,
  output logic [DRV_W-1:0] drive,
  output logic [FRQ_W-1:0] freq,
  output logic [DIV_W-1:0] divv,
  output cfg_t             cfg
);
  logic [DRV_W-1:0] drive_d;
  logic [FRQ_W-1:0] freq_d;
  logic [DIV_W-1:0] div_d;
  cfg_t             cfg_d;

  always_comb begin
    drive_d = drive;
    freq_d  = freq;
    div_d   = divv;
    cfg_d   = cfg;
    if (we) begin
      case (addr)
        ADDR_CFG:   cfg_d   = cfg_t'(wdata[CFG_W-1:0]);
        ADDR_DRIVE: drive_d = wdata[DRV_W-1:0];
        ADDR_FREQ:  freq_d  = wdata[FRQ_W-1:0];
        ADDR_DIV:   div_d   = wdata[DIV_W-1:0];
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive <= '0;
      freq  <= FRQ_RST;
      divv  <= DIV_RST;
      cfg   <= '0;
    end else begin
      drive <= drive_d;
      freq  <= freq_d;
      divv  <= div_d;
      cfg   <= cfg_d;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CFG:   rdata = REG_W'(cfg);
      ADDR_DRIVE: rdata = REG_W'(drive);
      ADDR_FREQ:  rdata = REG_W'(freq);
      ADDR_DIV:   rdata = REG_W'(divv);
      default:    rdata = '0;
    endcase
  end

  // R2
  div_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_DIV) |=> (divv == $past(wdata[DIV_W-1:0])));
endmodule

// File: rtl/fan_pwm_prescale.sv
module fan_pwm_prescale #(
  parameter int DIV_W    = 8,
  parameter int DEF_DIV0 = 4,
  parameter int DEF_DIV1 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             override,
  input  logic             clk_sel,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  localparam logic [DIV_W-1:0] DEF0 = DIV_W'(DEF_DIV0);
  localparam logic [DIV_W-1:0] DEF1 = DIV_W'(DEF_DIV1);
  localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);

  logic [DIV_W-1:0] cnt, cnt_d;
  logic [DIV_W-1:0] eff_sh, eff_d, eff_new;

  always_comb begin
    if (override) eff_new = (div_val == '0) ? ONE : div_val;
    else          eff_new = clk_sel ? DEF1 : DEF0;
  end

  assign tick = (cnt >= eff_sh - ONE);

  always_comb begin
    cnt_d = tick ? '0 : cnt + ONE;
    eff_d = load ? eff_new : eff_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      eff_sh <= DEF0;
    end else begin
      cnt    <= cnt_d;
      eff_sh <= eff_d;
    end
  end

  // R8
  presc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < eff_sh) && (eff_sh != '0));
endmodule

// File: rtl/fan_pwm_core.sv
module fan_pwm_core #(
  parameter int                DRV_W   = 6,
  parameter int                FRQ_W   = 5,
  parameter logic [FRQ_W-1:0]  FRQ_RST = 5'h17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [DRV_W-1:0] drive,
  input  logic [FRQ_W-1:0] freq,
  input  logic             invert,
  output logic             wrap,
  output logic             fan_out
);
  localparam int CNT_W  = FRQ_W + 1;
  localparam int PROD_W = DRV_W + CNT_W;
  localparam logic [PROD_W-1:0] DRV_MAX = PROD_W'((1 << DRV_W) - 1);

  logic [CNT_W-1:0]  pcnt, pcnt_d;
  logic [FRQ_W-1:0]  f_sh, f_d;
  logic [CNT_W-1:0]  cmp_sh, cmp_d;
  logic [CNT_W-1:0]  term_sh, steps_new;
  logic [PROD_W-1:0] prod, cmp_full;
  logic              raw, out_d;

  assign term_sh   = {f_sh, 1'b0};
  assign steps_new = {freq, 1'b1};
  assign prod      = PROD_W'(drive) * PROD_W'(steps_new);
  assign cmp_full  = prod / DRV_MAX;
  assign wrap      = tick && (pcnt >= term_sh);
  assign raw       = (f_sh != '0) && (pcnt < cmp_sh);

  always_comb begin
    pcnt_d = pcnt;
    f_d    = f_sh;
    cmp_d  = cmp_sh;
    if (wrap) begin
      pcnt_d = '0;
      f_d    = freq;
      cmp_d  = cmp_full[CNT_W-1:0];
    end else if (tick) begin
      pcnt_d = pcnt + CNT_W'(1);
    end
    out_d = raw ^ invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt    <= '0;
      f_sh    <= FRQ_RST;
      cmp_sh  <= '0;
      fan_out <= 1'b0;
    end else begin
      pcnt    <= pcnt_d;
      f_sh    <= f_d;
      cmp_sh  <= cmp_d;
      fan_out <= out_d;
    end
  end

  // R3
  pcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= term_sh);

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(f_sh) && $stable(cmp_sh)));

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_sh == '0 && $stable(f_sh)) |=> (fan_out == $past(invert)));
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pwm_pkg::*;
#(
  parameter int DEF_DIV0 = 4,
  parameter int DEF_DIV1 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             reg_we,
  output logic [REG_W-1:0] reg_rdata,
  output logic             fan_out
);
  logic [1:0]       rst_sync;
  logic             rst_n_s;
  logic [DRV_W-1:0] drive;
  logic [FRQ_W-1:0] freq;
  logic [DIV_W-1:0] divv;
  cfg_t             cfg;
  logic             tick, wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  fan_pwm_regs i_regs (
    .clk   (clk),
    .rst_n (rst_n_s),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .we    (reg_we),
    .rdata (reg_rdata),
    .drive (drive),
    .freq  (freq),
    .divv  (divv),
    .cfg   (cfg)
  );

  fan_pwm_prescale #(
    .DIV_W    (DIV_W),
    .DEF_DIV0 (DEF_DIV0),
    .DEF_DIV1 (DEF_DIV1)
  ) i_presc (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (wrap),
    .override (cfg.override),
    .clk_sel  (cfg.clk_sel),
    .div_val  (divv),
    .tick     (tick)
  );

  fan_pwm_core #(
    .DRV_W   (DRV_W),
    .FRQ_W   (FRQ_W),
    .FRQ_RST (FRQ_RST)
  ) i_core (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (tick),
    .drive   (drive),
    .freq    (freq),
    .invert  (cfg.invert),
    .wrap    (wrap),
    .fan_out (fan_out)
  );
endmodule

// File: tb/test_fan_pwm_gen.sv
module test_fan_pwm_gen;
  logic       clk;
  logic       rst_n;
  logic [7:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic       fan_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fan_pwm_gen i_fan_pwm_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .fan_out   (fan_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [7:0]  drv;
    logic [7:0]  frq;
    logic [7:0]  cfg;
    logic [7:0]  dv;
    logic [15:0] hi;
    logic [15:0] per;
  } vec_t;

  // hi = floor(drv*(2F+1)/63)*D, per = (2F+1)*D
  localparam vec_t VECS [7] = '{
    '{8'h20, 8'h03, 8'h00, 8'h01, 16'd12, 16'd28},  // D=4
    '{8'h3E, 8'h05, 8'h00, 8'h01, 16'd40, 16'd44},  // D=4
    '{8'h10, 8'h1F, 8'h00, 8'h01, 16'd64, 16'd252}, // D=4
    '{8'h2A, 8'h02, 8'h04, 8'h01, 16'd24, 16'd40},  // D=8
    '{8'h15, 8'h04, 8'h02, 8'h03, 16'd9,  16'd27},  // D=3
    '{8'h30, 8'h01, 8'h03, 8'h00, 16'd2,  16'd3},   // D=1, inverted
    '{8'h01, 8'h1F, 8'h01, 8'h07, 16'd4,  16'd252}  // D=4, inverted
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input logic pol, output int hi, output int per);
    int guard;
    guard = 0; hi = 0; per = 0;
    while (((fan_out ^ pol) !== 1'b0) && guard < 20000) begin @(negedge clk); guard++; end
    while (((fan_out ^ pol) !== 1'b1) && guard < 20000) begin @(negedge clk); guard++; end
    while (((fan_out ^ pol) === 1'b1) && guard < 20000) begin hi++; @(negedge clk); guard++; end
    per = hi;
    while (((fan_out ^ pol) === 1'b0) && guard < 20000) begin per++; @(negedge clk); guard++; end
  endtask

  task automatic const_level(input logic lvl, input int n, output bit ok);
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fan_out !== lvl) ok = 1'b0;
    end
  endtask

  initial begin
    logic [7:0] d;
    int hi, per;
    bit ok;
    rst_n = 1'b0; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    rd(8'h4C, d); check(d == 8'h00, "R1 drive", d, 8'h00);
    rd(8'h4D, d); check(d == 8'h17, "R1 period", d, 8'h17);
    rd(8'h4E, d); check(d == 8'h01, "R1 divisor", d, 8'h01);
    rd(8'h4A, d); check(d == 8'h00, "R1 config", d, 8'h00);
    check(fan_out === 1'b0, "R1 fan_out", fan_out, 0);

    // R2 field widths and unmapped address
    wr(8'h4D, 8'hFF); rd(8'h4D, d); check(d == 8'h1F, "R2 period mask", d, 8'h1F);
    wr(8'h4C, 8'hFF); rd(8'h4C, d); check(d == 8'h3F, "R2 drive mask", d, 8'h3F);
    wr(8'h4A, 8'hFF); rd(8'h4A, d); check(d == 8'h07, "R2 config mask", d, 8'h07);
    wr(8'h4E, 8'hA5); rd(8'h4E, d); check(d == 8'hA5, "R2 divisor full", d, 8'hA5);
    rd(8'h00, d); check(d == 8'h00, "R2 unmapped", d, 0);
    wr(8'h4A, 8'h00); wr(8'h4E, 8'h01); wr(8'h4D, 8'h03); wr(8'h4C, 8'h00);
    idle(20000);

    // R3 R4 R5 R7 R8 table walk
    foreach (VECS[k]) begin
      wr(8'h4A, VECS[k].cfg);
      wr(8'h4E, VECS[k].dv);
      wr(8'h4D, VECS[k].frq);
      wr(8'h4C, VECS[k].drv);
      idle(600);
      measure(VECS[k].cfg[0], hi, per);
      check(hi == int'(VECS[k].hi), $sformatf("R4 R5 vec%0d active", k), hi, VECS[k].hi);
      check(per == int'(VECS[k].per), $sformatf("R3 R8 vec%0d period", k), per, VECS[k].per);
    end

    // R7 divisor ignored without override, but kept
    wr(8'h4A, 8'h00); wr(8'h4E, 8'h03); wr(8'h4D, 8'h03); wr(8'h4C, 8'h20);
    idle(600);
    measure(1'b0, hi, per);
    check(per == 28, "R7 period ignores divisor", per, 28);
    rd(8'h4E, d); check(d == 8'h03, "R7 divisor kept", d, 3);

    // R4 full and zero drive
    wr(8'h4C, 8'h3F); idle(200);
    const_level(1'b1, 100, ok); check(ok, "R4 drive 3Fh always active", fan_out, 1);
    wr(8'h4C, 8'h00); idle(200);
    const_level(1'b0, 100, ok); check(ok, "R4 drive 00h never active", fan_out, 0);

    // R10 polarity reaches pin within two cycles
    wr(8'h4A, 8'h01);
    @(negedge clk);
    check(fan_out === 1'b1, "R10 inversion", fan_out, 1);

    // R6 zero period value holds inactive level
    wr(8'h4C, 8'h3F); wr(8'h4D, 8'h00); idle(200);
    const_level(1'b1, 100, ok); check(ok, "R6 inverted idle", fan_out, 1);
    wr(8'h4A, 8'h00); idle(5);
    const_level(1'b0, 100, ok); check(ok, "R6 idle", fan_out, 0);

    // R9 change mid-pulse keeps current pulse
    wr(8'h4D, 8'h03); wr(8'h4C, 8'h20); idle(600);
    begin
      int guard;
      guard = 0; hi = 0;
      while (fan_out !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
      while (fan_out !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
      reg_addr = 8'h4C; reg_wdata = 8'h3E; reg_we = 1'b1;
      while (fan_out === 1'b1 && guard < 20000) begin
        hi++; @(negedge clk); reg_we = 1'b0; guard++;
      end
    end
    check(hi == 12, "R9 pulse in progress keeps old width", hi, 12);
    measure(1'b0, hi, per);
    check(hi == 24, "R9 next pulse uses new drive", hi, 24);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule